// File: doc/BRIEF.md
# Shadow-Reloaded PWM Timer with Event Triggers

This block is the timebase of a digitally controlled switching converter. A counter runs either as a sawtooth (count up, wrap to zero) or as a triangle (count up to the period, then back down to zero). The PWM pin is driven from a comparison between the counter and an active duty value. In sawtooth mode the pin has one moving edge per switching cycle. In triangle mode the pulse is centred and both edges move, so a new duty can act every half cycle.

Firmware may rewrite the period and duty at any moment through write strobes. These writes only land in holding (shadow) registers. The holding values are copied into the active registers on a chosen reload point: counter at zero, counter at period, both, or never. Because of this, a write in the middle of a ramp can never cut, double or invent a pulse. A separate one-clock event strobe can be placed at zero, at the period or at the duty match. In triangle mode a strobe at the peak or the valley falls in the middle of an on or off interval. That strobe is meant to start an ADC conversion or a control interrupt.

Top module: `pwm_shadow_timer`

## Requirements
- R1: While `rst` is high and on the first output cycle after it, `cnt_out` is 0 and `pwm_out` and `trig_out` are 0. After reset, the active period is the parameter `PER_INIT`, the active duty is 0 and the holding registers hold the same values.
- R2: With `mode_ud` = 0 and an active period P ≥ 1, `cnt_out` runs 0, 1, … P and then returns to 0, giving a cycle of P+1 clocks.
- R3: With `mode_ud` = 1 and P ≥ 1, `cnt_out` climbs from 0 to P and then falls back to 0. Each turning value is shown for one clock, giving a cycle of 2·P clocks.
- R4: `reload_sel` chooses when the holding values are copied to the active registers: 0 = on the clock edge at which the counter shown is 0; 1 = at the edge at which it equals the active period; 2 = at either of those edges; 3 = never. The counter step taken at that same edge still uses the old period.
- R5: Only the last value written to a holding register before a reload is loaded. A write in the same clock as a reload edge is kept for the next reload.
- R6: The active period and duty change only on a reload edge. A write during a ramp does not alter the pulse under way.
- R7: `pwm_out` is 1 when the active duty D is nonzero and either `cnt_out` < D or D ≥ P. It is 0 otherwise. So D = 0 keeps the pin low for the whole cycle and D ≥ P keeps it high. `pwm_out` is aligned to the same clock as `cnt_out`.
- R8: `trig_sel` selects the event strobe: 0 = `cnt_out` is 0, 1 = `cnt_out` equals the active period, 2 = `cnt_out` equals the active duty, 3 = never. `trig_out` is high in exactly the clock in which `cnt_out` shows that value. For P ≥ 1 it is never high on two consecutive clocks.
- R9: An active period of 0 parks the counter at 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_ud | input | 1 | 0 = sawtooth count, 1 = triangle count |
| reload_sel | input | 2 | Reload point select (see R4) |
| trig_sel | input | 2 | Event strobe select (see R8) |
| per_wr | input | 1 | Write strobe for the period holding register |
| per_wdata | input | CNT_W | Period value to hold |
| duty_wr | input | 1 | Write strobe for the duty holding register |
| duty_wdata | input | CNT_W | Duty value to hold |
| pwm_out | output | 1 | PWM pin |
| trig_out | output | 1 | One-clock event strobe |
| cnt_out | output | CNT_W | Counter value |

## Verification
The bench targets the moment where a duty written mid-ramp must not take effect. A design that copies holding values at once would cut the current pulse short. It also checks that a disabled reload keeps the old period forever; a design that ignores the disable would change the wrap value. Back-to-back writes must load only the final value, and the duty limits of zero and at or above the period must pin the output. A period of zero must park the counter. Finally, the event strobe must be a single clock wide, at the exact peak, valley or match clock: a one-cycle misalignment would move the ADC sample off the midpoint of the interval.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    RLD_AT_ZERO = 2'd0,
    RLD_AT_PEAK = 2'd1,
    RLD_AT_BOTH = 2'd2,
    RLD_NEVER   = 2'd3
  } reload_e;

  typedef enum logic [1:0] {
    EVT_ZERO  = 2'd0,
    EVT_PEAK  = 2'd1,
    EVT_MATCH = 2'd2,
    EVT_NONE  = 2'd3
  } evt_e;

  localparam int unsigned NUM_HOLD = 2;
  localparam int unsigned IDX_PER  = 0;
  localparam int unsigned IDX_DUTY = 1;

endpackage

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_ud,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic rising_q;
  logic rising_nxt;

  always_comb begin
    cnt_nxt    = cnt_q;
    rising_nxt = rising_q;
    if (per_act == ZERO) begin
      cnt_nxt    = ZERO;
      rising_nxt = 1'b1;
    end else if (!mode_ud) begin
      rising_nxt = 1'b1;
      cnt_nxt    = (cnt_q >= per_act) ? ZERO : cnt_q + ONE;
    end else if (rising_q) begin
      if (cnt_q >= per_act) begin
        cnt_nxt    = cnt_q - ONE;
        rising_nxt = 1'b0;
      end else begin
        cnt_nxt    = cnt_q + ONE;
      end
    end else begin
      if (cnt_q == ZERO) begin
        cnt_nxt    = ONE;
        rising_nxt = 1'b1;
      end else begin
        cnt_nxt    = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= ZERO;
      rising_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_nxt;
      rising_q <= rising_nxt;
    end
  end

  AST_SAW_BOUND: assert property (@(posedge clk) disable iff (rst)
    (!mode_ud && $past(!mode_ud) && per_act != ZERO) |-> (cnt_q <= per_act)); // R2

  AST_PARK_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(per_act) == ZERO) |-> (cnt_q == ZERO)); // R9

  AST_RESET_CNT: assert property (@(posedge clk)
    $past(rst) |-> (cnt_q == ZERO)); // R1

endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
  import pwm_timer_pkg::*;
#(
  parameter int unsigned      CNT_W    = 16,
  parameter logic [CNT_W-1:0] PER_INIT = 16'd99
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reload_sel,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_wdata,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] duty_act,
  output logic [CNT_W-1:0] per_nxt,
  output logic [CNT_W-1:0] duty_nxt
);

  reload_e rld_mode;
  logic    at_zero;
  logic    at_peak;
  logic    reload_now;

  logic [NUM_HOLD-1:0]            wr_vec;
  logic [NUM_HOLD-1:0][CNT_W-1:0] wdata_vec;
  logic [NUM_HOLD-1:0][CNT_W-1:0] rst_vec;
  logic [NUM_HOLD-1:0][CNT_W-1:0] hold_q;
  logic [NUM_HOLD-1:0][CNT_W-1:0] act_q;
  logic [NUM_HOLD-1:0][CNT_W-1:0] act_nxt;

  assign rld_mode = reload_e'(reload_sel);
  assign at_zero  = (cnt_i == '0);
  assign at_peak  = (cnt_i == act_q[IDX_PER]);

  always_comb begin
    unique case (rld_mode)
      RLD_AT_ZERO: reload_now = at_zero;
      RLD_AT_PEAK: reload_now = at_peak;
      RLD_AT_BOTH: reload_now = at_zero || at_peak;
      default:     reload_now = 1'b0;
    endcase
  end

  assign wr_vec    = {duty_wr, per_wr};
  assign wdata_vec = {duty_wdata, per_wdata};
  assign rst_vec   = {{CNT_W{1'b0}}, PER_INIT};

  for (genvar g = 0; g < NUM_HOLD; g++) begin : g_hold
    assign act_nxt[g] = reload_now ? hold_q[g] : act_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q[g] <= rst_vec[g];
        act_q[g]  <= rst_vec[g];
      end else begin
        if (wr_vec[g]) hold_q[g] <= wdata_vec[g];
        act_q[g] <= act_nxt[g];
      end
    end
  end

  assign per_act  = act_q[IDX_PER];
  assign duty_act = act_q[IDX_DUTY];
  assign per_nxt  = act_nxt[IDX_PER];
  assign duty_nxt = act_nxt[IDX_DUTY];

  AST_ACT_AT_EVENT: assert property (@(posedge clk) disable iff (rst)
    (per_act != $past(per_act) || duty_act != $past(duty_act))
      |-> ($past(cnt_i) == '0 || $past(cnt_i) == $past(per_act))); // R6

  AST_RELOAD_OFF: assert property (@(posedge clk) disable iff (rst)
    ($past(reload_sel) == 2'b11) |-> ($stable(per_act) && $stable(duty_act))); // R4

endmodule

// File: rtl/pwm_event_out.sv
module pwm_event_out
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] per_nxt,
  input  logic [CNT_W-1:0] duty_nxt,
  output logic             pwm_q,
  output logic             trig_q
);

  evt_e evt_mode;
  logic pwm_d;
  logic trig_d;

  assign evt_mode = evt_e'(trig_sel);

  always_comb begin
    if (duty_nxt == '0)            pwm_d = 1'b0;
    else if (duty_nxt >= per_nxt)  pwm_d = 1'b1;
    else                           pwm_d = (cnt_nxt < duty_nxt);
  end

  always_comb begin
    unique case (evt_mode)
      EVT_ZERO:  trig_d = (cnt_nxt == '0);
      EVT_PEAK:  trig_d = (cnt_nxt == per_nxt);
      EVT_MATCH: trig_d = (cnt_nxt == duty_nxt);
      default:   trig_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      pwm_q  <= pwm_d;
      trig_q <= trig_d;
    end
  end

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer #(
  parameter int unsigned      CNT_W    = 16,
  parameter logic [CNT_W-1:0] PER_INIT = 16'd99
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_ud,
  input  logic [1:0]       reload_sel,
  input  logic [1:0]       trig_sel,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_wdata,
  output logic             pwm_out,
  output logic             trig_out,
  output logic [CNT_W-1:0] cnt_out
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] per_act;
  logic [CNT_W-1:0] duty_act;
  logic [CNT_W-1:0] per_nxt;
  logic [CNT_W-1:0] duty_nxt;

  pwm_count_core #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .mode_ud (mode_ud),
    .per_act (per_act),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  pwm_shadow_bank #(.CNT_W(CNT_W), .PER_INIT(PER_INIT)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .reload_sel (reload_sel),
    .per_wr     (per_wr),
    .per_wdata  (per_wdata),
    .duty_wr    (duty_wr),
    .duty_wdata (duty_wdata),
    .cnt_i      (cnt_q),
    .per_act    (per_act),
    .duty_act   (duty_act),
    .per_nxt    (per_nxt),
    .duty_nxt   (duty_nxt)
  );

  pwm_event_out #(.CNT_W(CNT_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .trig_sel (trig_sel),
    .cnt_nxt  (cnt_nxt),
    .per_nxt  (per_nxt),
    .duty_nxt (duty_nxt),
    .pwm_q    (pwm_out),
    .trig_q   (trig_out)
  );

  assign cnt_out = cnt_q;

  AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
    (duty_act == '0) |-> !pwm_out); // R7

  AST_DUTY_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (duty_act != '0 && duty_act >= per_act) |-> pwm_out); // R7

  AST_TRIG_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    (trig_out && per_act != '0) |=> (!trig_out || per_act == '0)); // R8

  AST_TRIG_ZERO_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (trig_out && $past(trig_sel) == 2'b00) |-> (cnt_out == '0)); // R8

endmodule

// File: tb/pwm_shadow_timer_tb_top.sv
module pwm_shadow_timer_tb_top;

  localparam int unsigned      W        = 16;
  localparam logic [W-1:0]     PER_INIT = 16'd20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_ud = 1'b0;
  logic [1:0]   reload_sel = 2'd0;
  logic [1:0]   trig_sel = 2'd0;
  logic         per_wr = 1'b0;
  logic [W-1:0] per_wdata = '0;
  logic         duty_wr = 1'b0;
  logic [W-1:0] duty_wdata = '0;
  logic         pwm_out;
  logic         trig_out;
  logic [W-1:0] cnt_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pwm_shadow_timer #(.CNT_W(W), .PER_INIT(PER_INIT)) dut_i (
    .clk(clk), .rst(rst), .mode_ud(mode_ud), .reload_sel(reload_sel),
    .trig_sel(trig_sel), .per_wr(per_wr), .per_wdata(per_wdata),
    .duty_wr(duty_wr), .duty_wdata(duty_wdata),
    .pwm_out(pwm_out), .trig_out(trig_out), .cnt_out(cnt_out)
  );

  // Reference model built from the requirements
  logic [W-1:0] m_cnt, m_per, m_duty, m_hper, m_hduty;
  logic         m_up, m_trig;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0; m_up <= 1'b1; m_per <= PER_INIT; m_duty <= '0;
      m_hper <= PER_INIT; m_hduty <= '0; m_trig <= 1'b0;
    end else begin : step
      logic         ld;
      logic [W-1:0] nc, np, nd;
      logic         nu;
      ld = (reload_sel == 2'd0 && m_cnt == 0) ||
           (reload_sel == 2'd1 && m_cnt == m_per) ||
           (reload_sel == 2'd2 && (m_cnt == 0 || m_cnt == m_per));
      nu = m_up;
      if (m_per == 0) begin nc = 0; nu = 1'b1; end
      else if (!mode_ud) begin nu = 1'b1; nc = (m_cnt >= m_per) ? 0 : m_cnt + 1; end
      else if (m_up) begin
        if (m_cnt >= m_per) begin nc = m_cnt - 1; nu = 1'b0; end
        else nc = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin nc = 1; nu = 1'b1; end
        else nc = m_cnt - 1;
      end
      np = ld ? m_hper : m_per;
      nd = ld ? m_hduty : m_duty;
      case (trig_sel)
        2'd0: m_trig <= (nc == 0);
        2'd1: m_trig <= (nc == np);
        2'd2: m_trig <= (nc == nd);
        default: m_trig <= 1'b0;
      endcase
      m_cnt <= nc; m_up <= nu; m_per <= np; m_duty <= nd;
      if (per_wr)  m_hper  <= per_wdata;
      if (duty_wr) m_hduty <= duty_wdata;
    end
  end

  function automatic logic exp_pwm();
    if (m_duty == 0) return 1'b0;
    if (m_duty >= m_per) return 1'b1;
    return m_cnt < m_duty;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    check(cnt_out == m_cnt, "R2/R3 counter", cnt_out, m_cnt);
    check(pwm_out == exp_pwm(), "R7 pwm", pwm_out, exp_pwm());
    check(trig_out == m_trig, "R8 trigger", trig_out, m_trig);
  endtask

  task automatic write_vals(input logic [W-1:0] p, input logic [W-1:0] d,
                            input bit wp, input bit wd);
    per_wr = wp; per_wdata = p; duty_wr = wd; duty_wdata = d;
    @(negedge clk);
    per_wr = 1'b0; duty_wr = 1'b0;
  endtask

  task automatic wait_cnt(input logic [W-1:0] v);
    for (int i = 0; i < 2000; i++) begin
      if (cnt_out == v) return;
      @(negedge clk);
    end
  endtask

  // count pwm highs over n samples starting at current negedge
  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic         ud;
    logic [1:0]   rl;
    logic [1:0]   ts;
    logic [W-1:0] per;
    logic [W-1:0] duty;
    logic [W-1:0] cyc;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 2'd0, 2'd0, 16'd9,  16'd4,  16'd60},
    '{1'b0, 2'd1, 2'd1, 16'd7,  16'd7,  16'd40},
    '{1'b1, 2'd0, 2'd0, 16'd8,  16'd3,  16'd60},
    '{1'b1, 2'd1, 2'd1, 16'd6,  16'd0,  16'd50},
    '{1'b1, 2'd2, 2'd2, 16'd10, 16'd5,  16'd70},
    '{1'b0, 2'd2, 2'd2, 16'd5,  16'd2,  16'd40},
    '{1'b0, 2'd0, 2'd2, 16'd12, 16'd20, 16'd50},
    '{1'b1, 2'd1, 2'd0, 16'd4,  16'd2,  16'd40}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int hi, tcnt, mx;
    bit prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cnt_out == 0, "R1 reset cnt", cnt_out, 0);
    check(pwm_out == 0, "R1 reset pwm", pwm_out, 0);
    check(trig_out == 0, "R1 reset trig", trig_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check(cnt_out == 1, "R1 first count", cnt_out, 1);

    foreach (VECS[k]) begin
      mode_ud = VECS[k].ud; reload_sel = VECS[k].rl; trig_sel = VECS[k].ts;
      compare_model();
      write_vals(VECS[k].per, VECS[k].duty, 1'b1, 1'b1);
      for (int c = 0; c < int'(VECS[k].cyc); c++) begin
        compare_model();
        @(negedge clk);
      end
    end

    // Directed tests, fresh reset
    rst = 1'b1; mode_ud = 1'b0; reload_sel = 2'd0; trig_sel = 2'd3;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mx = 0;
    for (int i = 0; i < 25; i++) begin
      if (int'(cnt_out) > mx) mx = cnt_out;
      @(negedge clk);
    end
    check(mx == PER_INIT, "R1 initial period", mx, PER_INIT);

    // R4: reload disabled keeps the old period
    reload_sel = 2'd3;
    write_vals(16'd5, 16'd0, 1'b1, 1'b0);
    mx = 0;
    for (int i = 0; i < 60; i++) begin
      if (int'(cnt_out) > mx) mx = cnt_out;
      @(negedge clk);
    end
    check(mx == PER_INIT, "R4 reload off", mx, PER_INIT);

    // R5: last write wins
    reload_sel = 2'd0;
    write_vals(16'd9, 16'd3, 1'b1, 1'b1);
    write_vals(16'd9, 16'd6, 1'b0, 1'b1);
    wait_cnt(0); @(negedge clk); wait_cnt(0);
    count_high(10, hi);
    check(hi == 6, "R5 last write duty", hi, 6);

    // R6: mid-ramp write does not alter current pulse
    wait_cnt(2);
    write_vals(16'd0, 16'd1, 1'b0, 1'b1);
    count_high(7, hi);
    check(hi == 3, "R6 mid-ramp unchanged", hi, 3);
    count_high(10, hi);
    check(hi == 1, "R6 new duty after reload", hi, 1);

    // R7: duty limits
    write_vals(16'd0, 16'd0, 1'b0, 1'b1);
    wait_cnt(0); @(negedge clk); wait_cnt(0);
    count_high(10, hi);
    check(hi == 0, "R7 duty zero low", hi, 0);
    write_vals(16'd0, 16'd15, 1'b0, 1'b1);
    wait_cnt(0); @(negedge clk); wait_cnt(0);
    count_high(10, hi);
    check(hi == 10, "R7 duty above period high", hi, 10);

    // R9: period zero parks the counter
    write_vals(16'd0, 16'd15, 1'b1, 1'b0);
    wait_cnt(0); repeat (3) @(negedge clk);
    mx = 0;
    for (int i = 0; i < 5; i++) begin
      if (int'(cnt_out) > mx) mx = cnt_out;
      @(negedge clk);
    end
    check(mx == 0, "R9 parked at zero", mx, 0);

    // R8: peak strobe, one clock wide, aligned to cnt == period
    trig_sel = 2'd1;
    write_vals(16'd9, 16'd4, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    tcnt = 0; prev = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (trig_out) begin
        tcnt++;
        check(cnt_out == 9, "R8 strobe alignment", cnt_out, 9);
        check(!prev, "R8 strobe width", 1, 0);
      end
      prev = trig_out;
      @(negedge clk);
    end
    check(tcnt == 2, "R8 strobe count", tcnt, 2);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule